// File: doc/BRIEF.md
# Writable ISA-Configuration Register Unit

This unit holds the machine-level register that reports which instruction-set extensions a 64-bit core currently exposes, and lets machine-mode software turn extensions off and back on at run time. Software reaches it through a simple CSR port: an address, write data and a write enable, with combinational read data. A write is not stored as given. It is first reduced to the extensions the build supports. Dependent extensions are then cleared together. A write that would drop compressed-instruction support while the next fetch address is only 2-byte aligned is discarded as a whole.

The rest of the core sees one enable line per extension letter (bit 0 = A through bit 25 = Z). It also sees a one-cycle reinitialize strobe whenever an extension comes back on, so that logic owning that extension's private state can clear it. The same port serves the read-only identity registers: vendor, architecture and implementation IDs come from parameters, and the hart ID comes from a per-hart strap input.

Top module: `isa_cfg_unit`

## Requirements
- R1: When a clock edge sees rst_n low, the unit enables every extension in the build mask EXT_MASK and drives ext_reinit to zero. Reading address 0x301 then returns the MXL parameter in bits 63:62, zeros in bits 61:26, and the extension flags in bits 25:0.
- R2: Extension bits that are absent from EXT_MASK read as zero and ignore writes. Bits 63:26 of address 0x301 ignore writes, so the base-width field 63:62 always reads MXL.
- R3: When a legalized write has F (bit 5) clear, D (bit 3) is committed clear as well.
- R4: When a legalized write has U (bit 20) clear, S (bit 18) is committed clear as well.
- R5: E (bit 4) cannot be written. It reads as the inverse of I (bit 8), except that it reads 0 when MXL is zero and no other extension bit is set.
- R6: A write to 0x301 is dropped as a whole, and the register keeps its old value, when all three of these hold: C (bit 2) is currently set, the legalized value has C clear, and next_pc bit 1 is 1.
- R7: A write commits on a clock edge only when csr_we is high, csr_addr is 0x301 and R6 does not apply. ext_en shows the committed flags from the cycle after that edge, so a disabled extension's enable goes low then.
- R8: When a commit turns a flag from 0 to 1, including the derived E flag, the matching ext_reinit bit is high for exactly the next cycle and is low otherwise.
- R9: Reads of 0xF11, 0xF12 and 0xF13 return the VENDOR_ID, ARCH_ID and IMPL_ID parameters, zero-extended. A read of 0xF14 returns hart_id_strap. Any other address reads zero.
- R10: While csr_we is high with csr_addr in 0xF11 to 0xF14, csr_illegal is high in the same cycle, and the write changes nothing. csr_illegal is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 64 | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | 64 | Combinational CSR read data |
| csr_illegal | output | 1 | Write attempted to a read-only identity register |
| next_pc | input | 64 | Address of the next instruction to fetch |
| hart_id_strap | input | 64 | Per-hart ID value |
| ext_en | output | 26 | Per-extension enable, bit 0 = A |
| ext_reinit | output | 26 | One-cycle reinitialize strobe per extension |

## Verification
The bench builds two instances. The first uses the default mask (A, C, D, F, I, M, S, U), MXL = 2 and nonzero identity parameters. This brings dependency clearing, C-write suppression, reinitialize strobes and the identity reads within reach under random writes. The second uses MXL = 0 with only I in its mask. Clearing I there leaves the whole register zero, which exercises the exception to the E rule that the first instance can never reach.

// File: rtl/isa_cfg_pkg.sv
// Package: shared constants and helpers for the ISA-configuration unit.
// Assumes a 64-bit register with one flag per letter A..Z in bits 25:0.
package isa_cfg_pkg;
    localparam int XLEN    = 64;
    localparam int NEXT    = 26;
    localparam int MXL_W   = 2;
    localparam int ADDR_W  = 12;
    localparam int VID_W   = 32;

    localparam int BIT_C = 2;
    localparam int BIT_D = 3;
    localparam int BIT_E = 4;
    localparam int BIT_F = 5;
    localparam int BIT_I = 8;
    localparam int BIT_S = 18;
    localparam int BIT_U = 20;

    localparam logic [ADDR_W-1:0] A_ISA   = 12'h301;
    localparam logic [ADDR_W-1:0] A_VEND  = 12'hF11;
    localparam logic [ADDR_W-1:0] A_ARCH  = 12'hF12;
    localparam logic [ADDR_W-1:0] A_IMPL  = 12'hF13;
    localparam logic [ADDR_W-1:0] A_HART  = 12'hF14;

    // Visible flags from stored flags: E is derived from I, except when
    // the base field is zero and nothing else is set.
    function automatic logic [NEXT-1:0] isa_view(input logic [NEXT-1:0] st,
                                                 input logic mxl_zero);
        logic [NEXT-1:0] v;
        v        = st;
        v[BIT_E] = ~st[BIT_I] & ~(mxl_zero & (st == '0));
        return v;
    endfunction
endpackage

// File: rtl/isa_wr_legalize.sv
// Module: turns raw write data into a legal extension set and decides
// whether the write must be suppressed. Purely combinational.
// Assumes cur_ext already obeys the mask and dependency rules.
module isa_wr_legalize
    import isa_cfg_pkg::*;
#(
    parameter logic [NEXT-1:0] EXT_MASK = 26'h014112D
) (
    input  logic [NEXT-1:0] cur_ext,
    input  logic [NEXT-1:0] raw_ext,
    input  logic            pc_half,
    output logic [NEXT-1:0] legal_ext,
    output logic            suppress
);
    logic [NEXT-1:0] masked;

    // Gate each flag with the build mask; E is never stored.
    for (genvar i = 0; i < NEXT; i++) begin : g_gate
        if (EXT_MASK[i] && (i != BIT_E)) begin : g_keep
            assign masked[i] = raw_ext[i];
        end else begin : g_zero
            assign masked[i] = 1'b0;
        end
    end

    // Apply dependency clearing, then evaluate the alignment hazard.
    always_comb begin
        legal_ext = masked;
        if (!legal_ext[BIT_F]) legal_ext[BIT_D] = 1'b0;
        if (!legal_ext[BIT_U]) legal_ext[BIT_S] = 1'b0;
        suppress = cur_ext[BIT_C] & ~legal_ext[BIT_C] & pc_half;
    end
endmodule

// File: rtl/isa_ext_state.sv
// Module: holds the committed extension flags and produces the
// reinitialize strobes for flags that turn on at a commit.
// Assumes legal_ext is already legalized and commit is qualified.
module isa_ext_state
    import isa_cfg_pkg::*;
#(
    parameter logic [NEXT-1:0] EXT_MASK = 26'h014112D,
    parameter bit              MXL_ZERO = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [NEXT-1:0] legal_ext,
    output logic [NEXT-1:0] stored,
    output logic [NEXT-1:0] reinit
);
    localparam logic [NEXT-1:0] RST_EXT = EXT_MASK & ~(NEXT'(1) << BIT_E);

    logic [NEXT-1:0] view_now;
    logic [NEXT-1:0] view_new;

    // Visible flags before and after a candidate commit.
    always_comb begin
        view_now = isa_view(stored, MXL_ZERO);
        view_new = isa_view(legal_ext, MXL_ZERO);
    end

    // Commit register and one-cycle strobe on rising flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= RST_EXT;
            reinit <= '0;
        end else begin
            reinit <= commit ? (view_new & ~view_now) : '0;
            if (commit) stored <= legal_ext;
        end
    end
endmodule

// File: rtl/isa_csr_readmux.sv
// Module: read data selection for the ISA register and the identity
// block, plus detection of writes to read-only identity addresses.
module isa_csr_readmux
    import isa_cfg_pkg::*;
#(
    parameter logic [MXL_W-1:0] MXL       = 2'd2,
    parameter logic [VID_W-1:0] VENDOR_ID = '0,
    parameter logic [XLEN-1:0]  ARCH_ID   = '0,
    parameter logic [XLEN-1:0]  IMPL_ID   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NEXT-1:0]   view,
    input  logic [XLEN-1:0]   strap,
    output logic [XLEN-1:0]   rdata,
    output logic              illegal
);
    localparam int PAD = XLEN - MXL_W - NEXT;

    logic id_hit;

    // Address decode and data select.
    always_comb begin
        id_hit = 1'b0;
        unique case (addr)
            A_ISA:   rdata = {MXL, {PAD{1'b0}}, view};
            A_VEND:  begin rdata = {{(XLEN-VID_W){1'b0}}, VENDOR_ID}; id_hit = 1'b1; end
            A_ARCH:  begin rdata = ARCH_ID; id_hit = 1'b1; end
            A_IMPL:  begin rdata = IMPL_ID; id_hit = 1'b1; end
            A_HART:  begin rdata = strap;   id_hit = 1'b1; end
            default: rdata = '0;
        endcase
        illegal = we & id_hit;
    end
endmodule

// File: rtl/isa_cfg_unit.sv
// Module: top of the writable ISA-configuration register unit.
// Assumes EXT_MASK is self-consistent (D only with F, S only with U).
module isa_cfg_unit
    import isa_cfg_pkg::*;
#(
    parameter logic [MXL_W-1:0] MXL       = 2'd2,
    parameter logic [NEXT-1:0]  EXT_MASK  = 26'h014112D,
    parameter logic [VID_W-1:0] VENDOR_ID = '0,
    parameter logic [XLEN-1:0]  ARCH_ID   = '0,
    parameter logic [XLEN-1:0]  IMPL_ID   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              csr_we,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   hart_id_strap,
    output logic [NEXT-1:0]   ext_en,
    output logic [NEXT-1:0]   ext_reinit
);
    localparam bit MXL_ZERO = (MXL == '0);

    logic [NEXT-1:0] stored;
    logic [NEXT-1:0] legal_ext;
    logic            suppress;
    logic            commit;

    isa_wr_legalize #(.EXT_MASK(EXT_MASK)) u_leg (
        .cur_ext   (stored),
        .raw_ext   (csr_wdata[NEXT-1:0]),
        .pc_half   (next_pc[1]),
        .legal_ext (legal_ext),
        .suppress  (suppress)
    );

    // Qualify the commit on enable, address and the alignment hazard.
    always_comb commit = csr_we & (csr_addr == A_ISA) & ~suppress;

    isa_ext_state #(.EXT_MASK(EXT_MASK), .MXL_ZERO(MXL_ZERO)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .legal_ext (legal_ext),
        .stored    (stored),
        .reinit    (ext_reinit)
    );

    // Enables follow the visible flags of the committed state.
    always_comb ext_en = isa_view(stored, MXL_ZERO);

    isa_csr_readmux #(
        .MXL(MXL), .VENDOR_ID(VENDOR_ID), .ARCH_ID(ARCH_ID), .IMPL_ID(IMPL_ID)
    ) u_rd (
        .addr    (csr_addr),
        .we      (csr_we),
        .view    (ext_en),
        .strap   (hart_id_strap),
        .rdata   (csr_rdata),
        .illegal (csr_illegal)
    );
endmodule

// File: rtl/isa_cfg_checker.sv
// Module: property checks for isa_cfg_unit, attached through bind.
module isa_cfg_checker
    import isa_cfg_pkg::*;
#(
    parameter logic [MXL_W-1:0] MXL      = 2'd2,
    parameter logic [NEXT-1:0]  EXT_MASK = 26'h014112D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [XLEN-1:0]   csr_wdata,
    input logic              csr_we,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              csr_illegal,
    input logic [XLEN-1:0]   next_pc,
    input logic [XLEN-1:0]   hart_id_strap,
    input logic [NEXT-1:0]   ext_en,
    input logic [NEXT-1:0]   ext_reinit
);
    localparam logic [NEXT-1:0] ALLOWED = EXT_MASK | (NEXT'(1) << BIT_E);

    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en & ~ALLOWED) == '0);
    p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_ISA) |-> (csr_rdata[XLEN-1 -: MXL_W] == MXL));
    p_dep_fd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en[BIT_D] |-> ext_en[BIT_F]);
    p_dep_us_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en[BIT_S] |-> ext_en[BIT_U]);
    p_e_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en[BIT_I] | (MXL != '0)) |-> (ext_en[BIT_E] == ~ext_en[BIT_I]));
    p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == A_ISA && next_pc[1] && ext_en[BIT_C] && !csr_wdata[BIT_C])
        |=> $stable(ext_en));
    p_noaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_addr == A_ISA) |=> $stable(ext_en));
    p_reinit_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_reinit & ~ext_en) == '0);
    p_reinit_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_reinit != '0) |-> ((ext_reinit & $past(ext_en)) == '0));
    p_hart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_HART) |-> (csr_rdata == hart_id_strap));
    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(ext_en));
endmodule

bind isa_cfg_unit isa_cfg_checker #(.MXL(MXL), .EXT_MASK(EXT_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .next_pc(next_pc), .hart_id_strap(hart_id_strap), .ext_en(ext_en),
    .ext_reinit(ext_reinit)
);

// File: tb/sim_isa_cfg_unit.sv
module sim_isa_cfg_unit;
    localparam int CLK_P = 10;
    localparam logic [25:0] MASK0 = 26'h014112D;
    localparam logic [25:0] MASK1 = 26'h0000100;
    localparam logic [31:0] VID   = 32'h0000_0A5B;
    localparam logic [63:0] AID   = 64'h8000_0000_0000_0007;
    localparam logic [63:0] IID   = 64'h0120_0000_0000_0000;
    localparam logic [63:0] STRAP = 64'h0000_0000_0000_0003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wd = '0;
    logic we = 1'b0;
    logic [63:0] pc = '0;
    logic [63:0] rd;
    logic ill;
    logic [25:0] en, ri;
    logic [11:0] addr1 = '0;
    logic [63:0] wd1 = '0;
    logic we1 = 1'b0;
    logic [63:0] rd1;
    logic ill1;
    logic [25:0] en1, ri1;

    int checks = 0;
    int fails = 0;
    logic [25:0] m0, m1;

    always #(CLK_P/2) clk = ~clk;

    isa_cfg_unit #(.MXL(2'd2), .EXT_MASK(MASK0), .VENDOR_ID(VID),
                   .ARCH_ID(AID), .IMPL_ID(IID)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_wdata(wd), .csr_we(we),
        .csr_rdata(rd), .csr_illegal(ill), .next_pc(pc), .hart_id_strap(STRAP),
        .ext_en(en), .ext_reinit(ri));

    isa_cfg_unit #(.MXL(2'd0), .EXT_MASK(MASK1)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr1), .csr_wdata(wd1), .csr_we(we1),
        .csr_rdata(rd1), .csr_illegal(ill1), .next_pc(64'h0), .hart_id_strap(64'h0),
        .ext_en(en1), .ext_reinit(ri1));

    function automatic logic [25:0] f_view(logic [25:0] st, bit mz);
        logic [25:0] v;
        v = st;
        v[4] = ~st[8] & ~(mz & (st == '0));
        return v;
    endfunction

    function automatic logic [25:0] f_legal(logic [25:0] raw, logic [25:0] mask);
        logic [25:0] w;
        w = raw & mask & ~26'h10;
        if (!w[5]) w[3] = 1'b0;
        if (!w[20]) w[18] = 1'b0;
        return w;
    endfunction

    function automatic logic [63:0] f_read0(logic [11:0] a, logic [25:0] st);
        case (a)
            12'h301: return {2'd2, 36'h0, f_view(st, 1'b0)};
            12'hF11: return {32'h0, VID};
            12'hF12: return AID;
            12'hF13: return IID;
            12'hF14: return STRAP;
            default: return 64'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access on u0: drive at negedge, check comb outputs, step, check state.
    task automatic acc0(logic [11:0] a, logic [63:0] d, logic w, logic pc1, string req);
        logic [25:0] lg, nxt, er;
        bit supp, com, idh;
        @(negedge clk);
        addr = a; wd = d; we = w; pc = {62'h0, pc1, 1'b0};
        #1;
        idh = (a >= 12'hF11) && (a <= 12'hF14);
        chk({req, " R9 rdata"}, rd, f_read0(a, m0));
        chk({req, " R10 illegal"}, {63'h0, ill}, {63'h0, w & idh});
        lg = f_legal(d[25:0], MASK0);
        supp = m0[2] && !lg[2] && pc1;
        com = w && (a == 12'h301) && !supp;
        nxt = com ? lg : m0;
        er = com ? (f_view(lg, 1'b0) & ~f_view(m0, 1'b0)) : '0;
        m0 = nxt;
        @(negedge clk);
        we = 1'b0;
        #1;
        chk({req, " R7 en"}, {38'h0, en}, {38'h0, f_view(m0, 1'b0)});
        chk({req, " R8 reinit"}, {38'h0, ri}, {38'h0, er});
    endtask

    task automatic acc1(logic [63:0] d, string req);
        @(negedge clk);
        addr1 = 12'h301; wd1 = d; we1 = 1'b1;
        @(negedge clk);
        we1 = 1'b0;
        m1 = f_legal(d[25:0], MASK1);
        #1;
        chk({req, " R5 u1 en"}, {38'h0, en1}, {38'h0, f_view(m1, 1'b1)});
        chk({req, " R5 u1 rd"}, rd1, {38'h0, f_view(m1, 1'b1)});
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m0 = MASK0;
        m1 = MASK1;
        #1;
        // R1 reset state
        chk("R1 en", {38'h0, en}, {38'h0, f_view(MASK0, 1'b0)});
        chk("R1 reinit", {38'h0, ri}, 64'h0);
        addr = 12'h301;
        #1;
        chk("R1 read", rd, {2'd2, 36'h0, MASK0});
        // R2 out-of-mask and upper bits ignored
        acc0(12'h301, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R2 all-ones");
        acc0(12'h301, 64'h0, 1'b1, 1'b0, "R2 zeros");
        chk("R2 base", {62'h0, rd[63:62]}, 64'd2);
        acc0(12'h301, 64'h0, 1'b1, 1'b0, "R5 E when I clear");
        chk("R5 e bit", {63'h0, en[4]}, 64'd1);
        // R8 re-enable all
        acc0(12'h301, {38'h0, MASK0}, 1'b1, 1'b0, "R8 reenable");
        // R3 F clear with D set
        acc0(12'h301, {38'h0, MASK0 & ~26'h20}, 1'b1, 1'b0, "R3 F0 D1");
        chk("R3 d bit", {63'h0, en[3]}, 64'd0);
        acc0(12'h301, {38'h0, MASK0}, 1'b1, 1'b0, "R8 again");
        // R4 U clear with S set
        acc0(12'h301, {38'h0, MASK0 & ~26'h100000}, 1'b1, 1'b0, "R4 U0 S1");
        chk("R4 s bit", {63'h0, en[18]}, 64'd0);
        // R6 clear C at misaligned pc: whole write dropped
        acc0(12'h301, {38'h0, MASK0 & ~26'h24}, 1'b1, 1'b1, "R6 suppressed");
        chk("R6 c kept", {63'h0, en[2]}, 64'd1);
        acc0(12'h301, {38'h0, MASK0 & ~26'h4}, 1'b1, 1'b0, "R6 aligned");
        chk("R6 c cleared", {63'h0, en[2]}, 64'd0);
        // R7 other address and no-enable writes
        acc0(12'h300, 64'h0, 1'b1, 1'b0, "R7 other addr");
        acc0(12'h301, 64'h0, 1'b0, 1'b0, "R7 no we");
        // R9/R10 identity block
        for (int k = 0; k < 4; k++) acc0(12'hF11 + 12'(k), 64'h0, 1'b1, 1'b0, "R10 id write");
        acc0(12'h7C0, 64'h0, 1'b0, 1'b0, "R9 unmapped");
        // R5 zero-register exception on u1
        acc1(64'h0, "R5 all zero");
        chk("R5 e zero", {63'h0, en1[4]}, 64'd0);
        acc1(64'h100, "R5 I set");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [63:0] d;
            int r;
            r = $urandom % 8;
            if (r < 4 || r == 7) a = 12'h301;
            else if (r == 4) a = 12'hF11 + 12'($urandom % 4);
            else if (r == 5) a = 12'h300;
            else a = 12'hF14;
            d = {$urandom, $urandom};
            if ($urandom % 2 == 1) d = d | {38'h0, MASK0 & ~26'h4};
            acc0(a, d, ($urandom % 4) != 0, $urandom % 2 == 1, "rnd R3 R4 R6");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule